// File: doc/BRIEF.md
# Host-to-Sound Command Mailbox

This block carries one command byte from a 16-bit host bus to an 8-bit sound processor bus. When the host writes the command word address with the low byte lane enabled, the low eight data bits are stored and an interrupt request toward the sound processor goes high. The request stays high until the sound side pulses an acknowledge input.

The sound processor reads the stored byte at one fixed address in its own space. A read never changes the stored byte. Both buses share one clock. The block holds no return path from the sound side to the host.

Top module: `snd_cmd_mailbox`

## Requirements
- R1: After reset the stored command byte is 0x00 and `snd_irq` is low.
- R2: A host write to address `HOST_CMD_ADDR` (default 0x84000E, compared on bits 23:1) with `host_be[0]` set stores `host_wdata[7:0]` in the next cycle.
- R3: A host write with `host_be[0]` clear, such as a write with only `host_be[1]` set, changes neither the stored byte nor `snd_irq`.
- R4: Each accepted host write sets `snd_irq` in the next cycle, and `snd_irq` stays high until an acknowledge arrives.
- R5: A one-cycle pulse on `snd_ack` clears `snd_irq` in the next cycle, unless an accepted host write happens in the same cycle. In that case `snd_irq` stays high.
- R6: An accepted host write while `snd_irq` is high replaces the stored byte, and `snd_irq` stays high.
- R7: A sound read at address `SND_CMD_ADDR` (default 0xE800) returns the stored byte on `snd_rdata` and drives `snd_rvalid` high. Both outputs are combinational in the same cycle.
- R8: A sound read at any other address, or no sound read at all, gives `snd_rdata` = 0x00 and `snd_rvalid` low.
- R9: Sound reads do not change the stored byte or `snd_irq`.
- R10: Host writes to any address other than `HOST_CMD_ADDR` are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe, one cycle per access |
| host_addr | input | 24 | Host byte address |
| host_be | input | 2 | Byte-lane enables, bit 0 is the low lane |
| host_wdata | input | 16 | Host write data |
| snd_rd | input | 1 | Sound read strobe |
| snd_addr | input | 16 | Sound byte address |
| snd_rdata | output | 8 | Sound read data |
| snd_rvalid | output | 1 | High when a sound read hits the command address |
| snd_ack | input | 1 | One-cycle interrupt acknowledge |
| snd_irq | output | 1 | Level interrupt request to the sound processor |

## Verification
The assertions assume each strobe is a plain one-cycle qualifier. They also assume `snd_ack` is a pulse that the sound side may raise whether or not a request is pending.

The random stimulus draws host addresses mostly from the command address and from near neighbours. It draws lane enables from all four combinations and sound addresses from the hit address and a few misses. Acknowledges are scattered at random.

Directed cases cover four situations:
- an acknowledge and a write in the same cycle
- two writes back to back with no acknowledge between them
- an upper-lane-only write
- a read while a request is pending

// File: rtl/snd_cmd_mailbox.sv
module snd_cmd_mailbox #(
  parameter int HOST_AW = 24,
  parameter int HOST_DW = 16,
  parameter int SND_AW  = 16,
  parameter int CMD_W   = 8,
  parameter logic [HOST_AW-1:0] HOST_CMD_ADDR = 24'h84000E,
  parameter logic [SND_AW-1:0]  SND_CMD_ADDR  = 16'hE800
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_wr,
  input  logic [HOST_AW-1:0] host_addr,
  input  logic [HOST_DW/8-1:0] host_be,
  input  logic [HOST_DW-1:0] host_wdata,
  input  logic               snd_rd,
  input  logic [SND_AW-1:0]  snd_addr,
  output logic [CMD_W-1:0]   snd_rdata,
  output logic               snd_rvalid,
  input  logic               snd_ack,
  output logic               snd_irq
);

  logic             host_hit;
  logic             accept;
  logic [CMD_W-1:0] cmd_q;
  logic             irq_q;

  assign host_hit = host_addr[HOST_AW-1:1] == HOST_CMD_ADDR[HOST_AW-1:1];
  assign accept   = host_wr && host_hit && host_be[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q <= '0;
      irq_q <= 1'b0;
    end else begin
      if (accept) cmd_q <= host_wdata[CMD_W-1:0];
      if (accept) irq_q <= 1'b1;
      else if (snd_ack) irq_q <= 1'b0;
    end
  end

  assign snd_irq    = irq_q;
  assign snd_rvalid = snd_rd && (snd_addr == SND_CMD_ADDR);
  assign snd_rdata  = snd_rvalid ? cmd_q : '0;

  p_reset_r1: assert property (@(posedge clk) !rst_n |=> (snd_irq == 1'b0));
  p_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (cmd_q == $past(host_wdata[CMD_W-1:0])));
  p_no_lane_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && !host_be[0] && !snd_ack) |=> ($stable(cmd_q) && $stable(snd_irq)));
  p_irq_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> snd_irq);
  p_irq_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (snd_irq && !snd_ack) |=> snd_irq);
  p_ack_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (snd_ack && !accept) |=> !snd_irq);
  p_rd_miss_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !snd_rvalid |-> (snd_rdata == '0));
  p_rd_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!host_wr && !snd_ack) |=> ($stable(cmd_q) && $stable(snd_irq)));

endmodule

// File: tb/snd_cmd_mailbox_tb.sv
module snd_cmd_mailbox_tb;
  logic        clk = 0;
  logic        rst_n;
  logic        host_wr;
  logic [23:0] host_addr;
  logic [1:0]  host_be;
  logic [15:0] host_wdata;
  logic        snd_rd;
  logic [15:0] snd_addr;
  logic [7:0]  snd_rdata;
  logic        snd_rvalid;
  logic        snd_ack;
  logic        snd_irq;

  int n_tests = 0;
  int n_fail  = 0;
  logic [7:0] m_cmd;
  logic       m_irq;

  always #10 clk = ~clk;

  snd_cmd_mailbox u_dut (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
    .host_be(host_be), .host_wdata(host_wdata), .snd_rd(snd_rd),
    .snd_addr(snd_addr), .snd_rdata(snd_rdata), .snd_rvalid(snd_rvalid),
    .snd_ack(snd_ack), .snd_irq(snd_irq)
  );

  function automatic logic exp_accept(logic wr, logic [23:0] a, logic [1:0] be);
    return wr && (a[23:1] == 23'h42_0007) && be[0];
  endfunction

  function automatic logic exp_rvalid(logic rd, logic [15:0] a);
    return rd && (a == 16'hE800);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic peek(string req);
    snd_rd = 1; snd_addr = 16'hE800;
    #1;
    check({req, " rdata"}, snd_rdata, m_cmd);
    check({req, " rvalid"}, snd_rvalid, 1);
    check({req, " irq"}, snd_irq, m_irq);
    snd_rd = 0;
  endtask

  task automatic cycle(logic wr, logic [23:0] a, logic [1:0] be, logic [15:0] d,
                       logic ack);
    @(negedge clk);
    host_wr = wr; host_addr = a; host_be = be; host_wdata = d; snd_ack = ack;
    @(posedge clk);
    if (exp_accept(wr, a, be)) begin m_cmd = d[7:0]; m_irq = 1; end
    else if (ack) m_irq = 0;
    @(negedge clk);
    host_wr = 0; snd_ack = 0;
  endtask

  initial begin
    #3_000_000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 0; host_wr = 0; host_addr = 0; host_be = 0; host_wdata = 0;
    snd_rd = 0; snd_addr = 0; snd_ack = 0;
    m_cmd = 0; m_irq = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    peek("R1");

    cycle(1, 24'h84000E, 2'b11, 16'hBEA5, 0); peek("R2 R4");
    cycle(0, 0, 0, 0, 1);                     peek("R5 ack");
    cycle(1, 24'h84000E, 2'b10, 16'h0077, 0); peek("R3 upper lane");
    cycle(1, 24'h84000F, 2'b01, 16'h0011, 0); peek("R2 odd byte addr");
    cycle(1, 24'h84000E, 2'b01, 16'h0022, 0); peek("R6 overwrite");
    cycle(1, 24'h84000C, 2'b01, 16'h0099, 0); peek("R10 miss");
    cycle(1, 24'h84000E, 2'b01, 16'h0033, 1); peek("R5 ack with write");
    repeat (3) begin
      @(negedge clk); snd_rd = 1; snd_addr = 16'hE800; @(negedge clk);
    end
    snd_rd = 0;
    peek("R9 reads");

    @(negedge clk); snd_rd = 1; snd_addr = 16'hE801; #1;
    check("R8 miss rdata", snd_rdata, 0);
    check("R8 miss rvalid", snd_rvalid, 0);
    snd_rd = 0; snd_addr = 16'hE800; #1;
    check("R8 no read", {snd_rvalid, snd_rdata}, 0);
    check("R7 hit", exp_rvalid(1, 16'hE800), 1);

    for (int i = 0; i < 400; i++) begin
      logic [23:0] a;
      logic [15:0] sa;
      case ($urandom_range(0, 3))
        0: a = 24'h84000C;
        1: a = 24'h84000F;
        default: a = 24'h84000E;
      endcase
      cycle($urandom_range(0, 1), a, 2'($urandom_range(0, 3)),
            16'($urandom), $urandom_range(0, 3) == 0);
      sa = ($urandom_range(0, 2) == 0) ? 16'hE000 : 16'hE800;
      snd_rd = $urandom_range(0, 1); snd_addr = sa; #1;
      check("R7 rand rvalid", snd_rvalid, exp_rvalid(snd_rd, sa));
      check("R7 rand rdata", snd_rdata, exp_rvalid(snd_rd, sa) ? m_cmd : 8'h00);
      check("R4 rand irq", snd_irq, m_irq);
      snd_rd = 0;
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule